// File: doc/BRIEF.md
# Graphic Display Controller Host Command Interface

This block is the processor-facing front end of a dot-matrix graphic display controller. A host on an 8-bit, strobe-qualified bus (strobe, active-low select, register select, read/write direction) first writes a 4-bit command code with the register select high, then writes one operand byte with the register select low; the operand write is what runs the command. Commands load the display parameter registers (mode, character pitch, characters per row, multiplex divisions, cursor line, start address), preset a 16-bit cursor address, or touch the display memory through a request/acknowledge port.

Memory commands always work at the cursor address and advance it by one when they finish. A memory read is pipelined one deep: the bus shows the byte fetched by the previous read, and the falling strobe then fetches the next byte. Bit set and bit clear are read-modify-write cycles on one selected bit. While any operand-triggered command runs, a busy flag is raised for a parameterised number of clocks; the host polls it by reading with the register select high.

Top module: `lcd_host_if`

## Requirements
- R1: A write with register select 1 stores bus bits 3:0 as the command code; bits 7:4 are ignored and the busy flag is not raised.
- R2: An operand write (register select 0) executes the stored code: 0 loads the 6-bit mode register from bits 5:0, 1 loads vertical pitch from bits 7:4 and horizontal pitch from bits 2:0, 2 loads the character count, 3 the division count, 4 the cursor line from bits 3:0, 8 and 9 the start address low and high bytes.
- R3: A read with register select 1 returns the busy flag on bit 7 and zeros below; after an accepted operand the flag stays high for BUSY_REG clocks (register codes), BUSY_RAM clocks (codes C, D) or BUSY_RMW clocks (codes E, F).
- R4: Any host write or read command arriving while busy is ignored.
- R5: Code A loads the cursor low byte; when the old low byte had bit 7 set and the new one has it clear, the high byte increments.
- R6: Code B replaces the cursor high byte and leaves the low byte unchanged.
- R7: With code C, each operand is written to memory at the cursor address and the cursor then increments.
- R8: With code D, a data read (register select 0) returns the output register, then loads it from memory at the cursor and increments the cursor; the first read after reset returns 0.
- R9: Code E clears and code F sets bit n of the memory byte at the cursor, n taken from operand bits 2:0 (0 is the LSB); other bits keep their values and the cursor increments.
- R10: Reset clears the mode register (display off, slave) and the cursor, and sets the horizontal pitch field to 5 (six dots).
- R11: With select high, strobes have no effect and the read data is not driven.
- R12: A memory request holds with a stable address until acknowledged, and is raised only while busy.
- R13: The cursor wraps from FFFF to 0000 on increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_e | input | 1 | Host strobe; writes and command starts act on its falling edge |
| bus_cs_n | input | 1 | Host select, active low |
| bus_rs | input | 1 | 1 = command/status, 0 = data |
| bus_rw | input | 1 | 1 = host read, 0 = host write |
| bus_din | input | 8 | Host write data |
| bus_dout | output | 8 | Host read data |
| bus_oe | output | 1 | High while read data is to be driven |
| busy | output | 1 | Command in progress |
| ram_req | output | 1 | Memory request |
| ram_we | output | 1 | Memory request is a write |
| ram_addr | output | 16 | Memory address (cursor) |
| ram_wdata | output | 8 | Memory write data |
| ram_ack | input | 1 | Memory acknowledge |
| ram_rdata | input | 8 | Memory read data |
| mode_reg | output | 6 | Mode register |
| vpitch | output | 4 | Vertical pitch minus one |
| hpitch | output | 3 | Horizontal pitch minus one |
| char_cnt | output | 8 | Characters per row minus one |
| time_div | output | 8 | Multiplex divisions minus one |
| cur_line | output | 4 | Cursor line minus one |
| start_addr | output | 16 | Display start address |
| cursor_addr | output | 16 | Cursor address |

## Verification
The hardest state to reach is a host access that lands while the busy counter is still running, since a well-behaved host never does this; the stimulus issues a second operand back to back without polling so that its falling strobe arrives inside the busy window, then checks that the target register kept its first value. The stale first read of the pipeline and the low-byte carry into the cursor high byte both need exact ordering of cursor loads, which the stimulus builds by reloading the cursor between read-modify-write and read sequences and by stepping the low byte across bit 7 in both directions.

// File: rtl/lcdh_pkg.sv
package lcdh_pkg;

    typedef enum logic [3:0] {
        OP_MODE  = 4'h0,
        OP_PITCH = 4'h1,
        OP_CHARS = 4'h2,
        OP_TDIV  = 4'h3,
        OP_CLINE = 4'h4,
        OP_SAL   = 4'h8,
        OP_SAH   = 4'h9,
        OP_CAL   = 4'hA,
        OP_CAH   = 4'hB,
        OP_MWR   = 4'hC,
        OP_MRD   = 4'hD,
        OP_BCLR  = 4'hE,
        OP_BSET  = 4'hF
    } op_e;

    typedef enum logic [1:0] {CL_REG, CL_RAM, CL_RMW} cls_e;

    typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_MRD, S_MWR} seq_e;

    // Operand writes: memory read code carries no memory action on a write.
    function automatic cls_e wr_class(logic [3:0] code);
        cls_e c;
        case (code)
            OP_MWR:           c = CL_RAM;
            OP_BCLR, OP_BSET: c = CL_RMW;
            default:          c = CL_REG;
        endcase
        return c;
    endfunction

    // Low-byte cursor load with carry into the high byte on a 1->0 bit 7.
    function automatic logic [15:0] cur_low_load(logic [15:0] cur, logic [7:0] lo);
        logic [7:0] hi;
        hi = cur[15:8] + {7'd0, cur[7] & ~lo[7]};
        return {hi, lo};
    endfunction

    function automatic logic [7:0] bit_edit(logic [7:0] b, logic [2:0] n, logic v);
        logic [7:0] r;
        r    = b;
        r[n] = v;
        return r;
    endfunction

endpackage

// File: rtl/lcdh_strobe.sv
module lcdh_strobe (
    input  logic clk,
    input  logic rst,
    input  logic bus_e,
    input  logic bus_cs_n,
    input  logic bus_rs,
    input  logic bus_rw,
    input  logic busy,
    output logic ir_wr,
    output logic opnd_wr,
    output logic dat_rd
);
    logic e_q;
    logic take;

    always_ff @(posedge clk) begin
        if (rst) e_q <= 1'b0;
        else     e_q <= bus_e;
    end

    assign take    = e_q & ~bus_e & ~bus_cs_n & ~busy;
    assign ir_wr   = take &  bus_rs & ~bus_rw;
    assign opnd_wr = take & ~bus_rs & ~bus_rw;
    assign dat_rd  = take & ~bus_rs &  bus_rw;
endmodule

// File: rtl/lcdh_regfile.sv
module lcdh_regfile
    import lcdh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ir_wr,
    input  logic        opnd_wr,
    input  logic [7:0]  din,
    input  logic        cur_inc,
    output logic [3:0]  ir_code,
    output logic [5:0]  mode_reg,
    output logic [3:0]  vpitch,
    output logic [2:0]  hpitch,
    output logic [7:0]  char_cnt,
    output logic [7:0]  time_div,
    output logic [3:0]  cur_line,
    output logic [15:0] start_addr,
    output logic [15:0] cursor_addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ir_code     <= 4'h0;
            mode_reg    <= 6'd0;
            vpitch      <= 4'd0;
            hpitch      <= 3'd5;
            char_cnt    <= 8'd0;
            time_div    <= 8'd0;
            cur_line    <= 4'd0;
            start_addr  <= 16'd0;
            cursor_addr <= 16'd0;
        end else begin
            if (ir_wr) ir_code <= din[3:0];
            if (opnd_wr) begin
                case (ir_code)
                    OP_MODE:  mode_reg <= din[5:0];
                    OP_PITCH: begin
                        vpitch <= din[7:4];
                        hpitch <= din[2:0];
                    end
                    OP_CHARS: char_cnt <= din;
                    OP_TDIV:  time_div <= din;
                    OP_CLINE: cur_line <= din[3:0];
                    OP_SAL:   start_addr[7:0]  <= din;
                    OP_SAH:   start_addr[15:8] <= din;
                    OP_CAL:   cursor_addr <= cur_low_load(cursor_addr, din);
                    OP_CAH:   cursor_addr[15:8] <= din;
                    default: ;
                endcase
            end else if (cur_inc) begin
                cursor_addr <= cursor_addr + 16'd1;
            end
        end
    end
endmodule

// File: rtl/lcdh_ram_seq.sv
module lcdh_ram_seq
    import lcdh_pkg::*;
#(
    parameter int unsigned BUSY_REG = 6,
    parameter int unsigned BUSY_RAM = 8,
    parameter int unsigned BUSY_RMW = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  ir_code,
    input  logic        opnd_wr,
    input  logic        dat_rd,
    input  logic [7:0]  din,
    input  logic [15:0] cursor,
    input  logic        ram_ack,
    input  logic [7:0]  ram_rdata,
    output logic        busy,
    output logic        cur_inc,
    output logic        ram_req,
    output logic        ram_we,
    output logic [15:0] ram_addr,
    output logic [7:0]  ram_wdata,
    output logic [7:0]  dor
);
    localparam int unsigned MAX_A = (BUSY_REG > BUSY_RAM) ? BUSY_REG : BUSY_RAM;
    localparam int unsigned MAX_C = (MAX_A > BUSY_RMW) ? MAX_A : BUSY_RMW;
    localparam int unsigned CNT_W = $clog2(MAX_C + 1);

    seq_e             state;
    logic [CNT_W-1:0] cnt;
    logic [7:0]       op_q;
    logic [7:0]       tmp_q;
    logic             set_q;
    logic             rd_go;
    cls_e             cls;

    assign rd_go = dat_rd & (ir_code == OP_MRD);
    assign cls   = wr_class(ir_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            cnt   <= '0;
            op_q  <= 8'd0;
            tmp_q <= 8'd0;
            set_q <= 1'b0;
            dor   <= 8'd0;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (opnd_wr) begin
                op_q  <= din;
                set_q <= ir_code[0];
                case (cls)
                    CL_RAM: begin cnt <= CNT_W'(BUSY_RAM); state <= S_WR;  end
                    CL_RMW: begin cnt <= CNT_W'(BUSY_RMW); state <= S_MRD; end
                    default: cnt <= CNT_W'(BUSY_REG);
                endcase
            end else if (rd_go) begin
                cnt   <= CNT_W'(BUSY_RAM);
                state <= S_RD;
            end else if (ram_ack) begin
                case (state)
                    S_RD: begin
                        dor   <= ram_rdata;
                        state <= S_IDLE;
                    end
                    S_MRD: begin
                        tmp_q <= bit_edit(ram_rdata, op_q[2:0], set_q);
                        state <= S_MWR;
                    end
                    S_WR, S_MWR: state <= S_IDLE;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        ram_req   = (state != S_IDLE);
        ram_we    = (state == S_WR) | (state == S_MWR);
        ram_wdata = (state == S_MWR) ? tmp_q : op_q;
    end

    assign ram_addr = cursor;
    assign cur_inc  = ram_ack & ((state == S_WR) | (state == S_RD) | (state == S_MWR));
    assign busy     = (cnt != '0) | (state != S_IDLE);
endmodule

// File: rtl/lcd_host_if.sv
module lcd_host_if
    import lcdh_pkg::*;
#(
    parameter int unsigned BUSY_REG = 6,
    parameter int unsigned BUSY_RAM = 8,
    parameter int unsigned BUSY_RMW = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_e,
    input  logic        bus_cs_n,
    input  logic        bus_rs,
    input  logic        bus_rw,
    input  logic [7:0]  bus_din,
    output logic [7:0]  bus_dout,
    output logic        bus_oe,
    output logic        busy,
    output logic        ram_req,
    output logic        ram_we,
    output logic [15:0] ram_addr,
    output logic [7:0]  ram_wdata,
    input  logic        ram_ack,
    input  logic [7:0]  ram_rdata,
    output logic [5:0]  mode_reg,
    output logic [3:0]  vpitch,
    output logic [2:0]  hpitch,
    output logic [7:0]  char_cnt,
    output logic [7:0]  time_div,
    output logic [3:0]  cur_line,
    output logic [15:0] start_addr,
    output logic [15:0] cursor_addr
);
    logic       ir_wr, opnd_wr, dat_rd, cur_inc;
    logic [3:0] ir_code;
    logic [7:0] dor;

    lcdh_strobe u_strobe (
        .clk(clk), .rst(rst), .bus_e(bus_e), .bus_cs_n(bus_cs_n),
        .bus_rs(bus_rs), .bus_rw(bus_rw), .busy(busy),
        .ir_wr(ir_wr), .opnd_wr(opnd_wr), .dat_rd(dat_rd)
    );

    lcdh_regfile u_regs (
        .clk(clk), .rst(rst), .ir_wr(ir_wr), .opnd_wr(opnd_wr),
        .din(bus_din), .cur_inc(cur_inc), .ir_code(ir_code),
        .mode_reg(mode_reg), .vpitch(vpitch), .hpitch(hpitch),
        .char_cnt(char_cnt), .time_div(time_div), .cur_line(cur_line),
        .start_addr(start_addr), .cursor_addr(cursor_addr)
    );

    lcdh_ram_seq #(
        .BUSY_REG(BUSY_REG), .BUSY_RAM(BUSY_RAM), .BUSY_RMW(BUSY_RMW)
    ) u_seq (
        .clk(clk), .rst(rst), .ir_code(ir_code), .opnd_wr(opnd_wr),
        .dat_rd(dat_rd), .din(bus_din), .cursor(cursor_addr),
        .ram_ack(ram_ack), .ram_rdata(ram_rdata), .busy(busy),
        .cur_inc(cur_inc), .ram_req(ram_req), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .dor(dor)
    );

    assign bus_dout = bus_rs ? {busy, 7'd0} : dor;
    assign bus_oe   = bus_e & ~bus_cs_n & bus_rw;
endmodule

// File: rtl/lcd_host_if_chk.sv
module lcd_host_if_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_e,
    input logic        bus_cs_n,
    input logic        bus_rs,
    input logic        bus_rw,
    input logic [7:0]  bus_dout,
    input logic        bus_oe,
    input logic        busy,
    input logic        ram_req,
    input logic        ram_ack,
    input logic [15:0] ram_addr,
    input logic [5:0]  mode_reg,
    input logic [2:0]  hpitch
);
    logic e_seen;
    logic fall;

    always_ff @(posedge clk) begin
        if (rst) e_seen <= 1'b0;
        else     e_seen <= bus_e;
    end
    assign fall = e_seen & ~bus_e & ~bus_cs_n;

    p_ir_no_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (fall && bus_rs && !bus_rw && !busy) |=> !busy);

    p_operand_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (fall && !bus_rs && !bus_rw && !busy) |=> busy);

    p_ignore_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (fall && busy) |=> ($stable(mode_reg) && $stable(hpitch)));

    p_reset_vals_r10: assert property (@(posedge clk)
        rst |=> (mode_reg == 6'd0 && hpitch == 3'd5));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (ram_req && !ram_ack) |=> (ram_req && $stable(ram_addr)));

    p_req_in_busy_r12: assert property (@(posedge clk) disable iff (rst)
        ram_req |-> busy);

    p_dout_steady_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && !bus_rs && !busy && $past(bus_oe && !bus_rs && !busy)) |-> $stable(bus_dout));
endmodule

bind lcd_host_if lcd_host_if_chk u_chk (
    .clk(clk), .rst(rst), .bus_e(bus_e), .bus_cs_n(bus_cs_n),
    .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .busy(busy), .ram_req(ram_req), .ram_ack(ram_ack), .ram_addr(ram_addr),
    .mode_reg(mode_reg), .hpitch(hpitch)
);

// File: tb/tb_lcd_host_if.sv
module tb_lcd_host_if;
    localparam int unsigned BR  = 6;
    localparam int unsigned BM  = 8;
    localparam int unsigned BX  = 12;
    localparam int          NV  = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_e = 1'b0, bus_cs_n = 1'b1, bus_rs = 1'b0, bus_rw = 1'b0;
    logic [7:0]  bus_din = 8'd0;
    logic [7:0]  bus_dout;
    logic        bus_oe, busy, ram_req, ram_we, ram_ack;
    logic [15:0] ram_addr, start_addr, cursor_addr;
    logic [7:0]  ram_wdata, ram_rdata, char_cnt, time_div;
    logic [5:0]  mode_reg;
    logic [3:0]  vpitch, cur_line;
    logic [2:0]  hpitch;
    logic [7:0]  mem [0:255];
    int          total = 0;
    int          bad   = 0;

    always #5 clk = ~clk;

    lcd_host_if #(.BUSY_REG(BR), .BUSY_RAM(BM), .BUSY_RMW(BX)) dut (
        .clk(clk), .rst(rst), .bus_e(bus_e), .bus_cs_n(bus_cs_n),
        .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .busy(busy),
        .ram_req(ram_req), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
        .mode_reg(mode_reg), .vpitch(vpitch), .hpitch(hpitch),
        .char_cnt(char_cnt), .time_div(time_div), .cur_line(cur_line),
        .start_addr(start_addr), .cursor_addr(cursor_addr)
    );

    // single-cycle memory model
    assign ram_ack   = ram_req;
    assign ram_rdata = mem[ram_addr[7:0]];
    always @(posedge clk) if (ram_req && ram_we) mem[ram_addr[7:0]] <= ram_wdata;

    // {rs, data, select, expected}; select: 0 none, 1 {vpitch,hpitch},
    // 2 char_cnt, 3 time_div, 4 cur_line, 5 start_addr, 6 cursor_addr, 7 mode_reg
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 8'h00, 3'd0, 16'h0000},
        {1'b0, 8'h3D, 3'd7, 16'h003D},
        {1'b1, 8'h01, 3'd0, 16'h0000},
        {1'b0, 8'h47, 3'd1, 16'h0027},
        {1'b1, 8'hF2, 3'd0, 16'h0000},
        {1'b0, 8'h27, 3'd2, 16'h0027},
        {1'b1, 8'h03, 3'd0, 16'h0000},
        {1'b0, 8'h3F, 3'd3, 16'h003F},
        {1'b1, 8'h04, 3'd0, 16'h0000},
        {1'b0, 8'h07, 3'd4, 16'h0007},
        {1'b1, 8'h08, 3'd0, 16'h0000},
        {1'b0, 8'h34, 3'd5, 16'h0034},
        {1'b1, 8'h09, 3'd0, 16'h0000},
        {1'b0, 8'h12, 3'd5, 16'h1234},
        {1'b1, 8'h0A, 3'd0, 16'h0000},
        {1'b0, 8'h80, 3'd6, 16'h0080},
        {1'b1, 8'h0B, 3'd0, 16'h0000},
        {1'b0, 8'h12, 3'd6, 16'h1280},
        {1'b1, 8'h0A, 3'd0, 16'h0000},
        {1'b0, 8'h10, 3'd6, 16'h1310}
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic hwrite(input logic rs, input logic [7:0] d, input logic sel_n = 1'b0);
        @(negedge clk);
        bus_cs_n = sel_n; bus_rs = rs; bus_rw = 1'b0; bus_din = d; bus_e = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_e = 1'b0;
        @(negedge clk);
        bus_cs_n = 1'b1;
    endtask

    task automatic hread(input logic rs, output logic [7:0] v, output logic oe, input logic sel_n = 1'b0);
        @(negedge clk);
        bus_cs_n = sel_n; bus_rs = rs; bus_rw = 1'b1; bus_e = 1'b1;
        @(negedge clk);
        v = bus_dout; oe = bus_oe;
        bus_e = 1'b0;
        @(negedge clk);
        bus_cs_n = 1'b1; bus_rw = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 100 && busy; k++) @(negedge clk);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
    endtask

    task automatic set_cursor(input logic [15:0] a);
        hwrite(1'b1, 8'h0A); hwrite(1'b0, a[7:0]); wait_idle();
        hwrite(1'b1, 8'h0B); hwrite(1'b0, a[15:8]); wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  v;
        logic        oe;
        int          n;
        logic [15:0] got;
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 mode", {10'd0, mode_reg}, 16'h0000);
        chk("R10 hpitch", {13'd0, hpitch}, 16'h0005);
        chk("R10 cursor", cursor_addr, 16'h0000);
        chk("R10 busy", {15'd0, busy}, 16'h0000);

        // table walk: R1 R2 R5 R6
        for (int i = 0; i < NV; i++) begin
            hwrite(VEC[i][27], VEC[i][26:19]);
            if (VEC[i][27]) chk("R1 no busy on code write", {15'd0, busy}, 16'h0000);
            wait_idle();
            case (VEC[i][18:16])
                3'd1: got = {9'd0, vpitch, hpitch};
                3'd2: got = {8'd0, char_cnt};
                3'd3: got = {8'd0, time_div};
                3'd4: got = {12'd0, cur_line};
                3'd5: got = start_addr;
                3'd6: got = cursor_addr;
                3'd7: got = {10'd0, mode_reg};
                default: got = 16'h0000;
            endcase
            if (VEC[i][18:16] == 3'd6) chk("R5 R6 cursor load", got, VEC[i][15:0]);
            else if (VEC[i][18:16] != 3'd0) chk("R2 register load", got, VEC[i][15:0]);
        end
        // R5: low byte without 1->0 on bit 7 gives no carry
        hwrite(1'b0, 8'h7F); wait_idle();
        chk("R5 no carry", cursor_addr, 16'h137F);

        // R3 busy length for register class and busy readback
        hwrite(1'b1, 8'h03);
        hwrite(1'b0, 8'h11);
        busy_len(n);
        chk("R3 busy reg clocks", 16'(n), 16'(BR));
        hwrite(1'b0, 8'h12);
        hread(1'b1, v, oe);
        chk("R3 status busy", {8'd0, v}, 16'h0080);
        wait_idle();
        hread(1'b1, v, oe);
        chk("R3 status idle", {8'd0, v}, 16'h0000);

        // R4 write during busy ignored
        hwrite(1'b1, 8'h02);
        hwrite(1'b0, 8'h10);
        hwrite(1'b0, 8'h33);
        wait_idle();
        chk("R4 ignored while busy", {8'd0, char_cnt}, 16'h0010);

        // R11 select high
        hwrite(1'b0, 8'h99, 1'b1);
        chk("R11 write deselected busy", {15'd0, busy}, 16'h0000);
        chk("R11 write deselected reg", {8'd0, char_cnt}, 16'h0010);
        hread(1'b1, v, oe, 1'b1);
        chk("R11 read not driven", {15'd0, oe}, 16'h0000);

        // R13 wrap with R7 write
        set_cursor(16'hFFFF);
        chk("R6 cursor FFFF", cursor_addr, 16'hFFFF);
        hwrite(1'b1, 8'h0C);
        hwrite(1'b0, 8'hC3);
        wait_idle();
        chk("R13 wrap", cursor_addr, 16'h0000);
        chk("R7 mem FF", {8'd0, mem[8'hFF]}, 16'h00C3);

        // R7 memory writes
        set_cursor(16'h0005);
        hwrite(1'b1, 8'h0C);
        hwrite(1'b0, 8'h5A);
        busy_len(n);
        chk("R3 busy ram clocks", 16'(n), 16'(BM));
        chk("R7 cursor inc", cursor_addr, 16'h0006);
        chk("R7 mem 5", {8'd0, mem[5]}, 16'h005A);
        hwrite(1'b0, 8'hA5); wait_idle();
        chk("R7 mem 6", {8'd0, mem[6]}, 16'h00A5);

        // R9 bit set and clear
        set_cursor(16'h0005);
        hwrite(1'b1, 8'h0F);
        hwrite(1'b0, 8'h00);
        busy_len(n);
        chk("R3 busy rmw clocks", 16'(n), 16'(BX));
        chk("R9 set bit0", {8'd0, mem[5]}, 16'h005B);
        chk("R9 cursor inc", cursor_addr, 16'h0006);
        set_cursor(16'h0005);
        hwrite(1'b1, 8'h0E);
        hwrite(1'b0, 8'h06); wait_idle();
        chk("R9 clear bit6", {8'd0, mem[5]}, 16'h001B);

        // R8 pipelined read
        set_cursor(16'h0005);
        hwrite(1'b1, 8'h0D);
        hread(1'b0, v, oe); wait_idle();
        chk("R8 stale first read", {8'd0, v}, 16'h0000);
        hread(1'b0, v, oe); wait_idle();
        chk("R8 second read", {8'd0, v}, 16'h001B);
        hread(1'b0, v, oe); wait_idle();
        chk("R8 third read", {8'd0, v}, 16'h00A5);
        chk("R8 cursor after reads", cursor_addr, 16'h0008);

        // R10 reset again after state change
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        chk("R10 mode after reset", {10'd0, mode_reg}, 16'h0000);
        chk("R10 hpitch after reset", {13'd0, hpitch}, 16'h0005);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule